// File: doc/BRIEF.md
# Fractional PLL output rate calculator

This block turns the programmed divider settings of a fractional-N frequency synthesizer into the output frequency in Hz. It takes two packed divider words and the reference frequency in Hz. From these it computes `Fin * (M*65536 + K) / ((P*65536) << S)` with a serial divider that produces one quotient bit per clock. A mode input chooses between an integer-only synthesizer, where the fractional term is zero, and a fractional one, where a signed 16-bit K trims the multiplier.

The caller places the two words, the reference frequency and the mode on the inputs and pulses `start_i`. The result appears on `freq_o` together with a one-cycle `done_o` pulse. A pre-divider of zero cannot be divided by. In that case the block reports `err_o` with a zero result at once and does not run the divider. Choosing the best divider settings for a wanted rate is outside this block.

Top module: `pll_rate_calc`

## Requirements
- R1: In `div0_i`, M is bits 21:12, P is bits 9:4 and S is bits 2:0. All other bits of `div0_i` have no effect on the result.
- R2: With `mode_i`=1 (fractional), K is `div1_i[15:0]` read as a two's-complement value from -32768 to 32767. Bits 31:16 of `div1_i` have no effect.
- R3: With `mode_i`=0 (integer), K is zero and `div1_i` has no effect on the result.
- R4: `freq_o` is the signed 64-bit quotient of `fin_i*(M*65536+K)` by `(P*65536)<<S`, truncated toward zero. This includes the case where `M*65536+K` is negative.
- R5: When P is nonzero, `done_o` is high for exactly one cycle. It rises 64 rising clock edges after the edge that accepts `start_i`, and `err_o` is low with it.
- R6: When P is zero, the edge that accepts `start_i` raises `done_o` and `err_o` together, and `freq_o` is 0.
- R7: While `done_o` is low, `freq_o` is 0 and `err_o` is 0. This includes the reset state.
- R8: A `start_i` pulse while a computation is running has no effect on that computation's result or on its timing.
- R9: A `start_i` that is high during the cycle in which `done_o` is high is accepted and begins a new computation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a computation when idle |
| mode_i | input | 1 | 0 integer variant, 1 fractional variant |
| div0_i | input | 32 | Divider word holding M, P and S |
| div1_i | input | 32 | Divider word holding K |
| fin_i | input | 32 | Reference frequency in Hz |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Zero pre-divider flag, valid with done_o |
| freq_o | output | 64 | Signed output frequency in Hz, valid with done_o |

## Verification
A result pulse and the acceptance of the next request can fall in the same cycle. The bench holds `start_i` high with new settings in exactly the cycle in which `done_o` is observed high. It then checks that the first result is intact and that the second request runs to its own full latency. The same collision is repeated with a zero pre-divider in the second request. In that case `done_o` stays high for a second cycle, now carrying `err_o`, and the bench checks that the two pulses carry their separate values.

// File: rtl/pllrate_pkg.sv
package pllrate_pkg;
  localparam int unsigned M_W    = 10;
  localparam int unsigned P_W    = 6;
  localparam int unsigned S_W    = 3;
  localparam int unsigned K_W    = 16;
  localparam int unsigned FRAC_W = 16;

  // field positions decoded by the divider word layout
  localparam int unsigned M_LSB = 12;
  localparam int unsigned P_LSB = 4;
  localparam int unsigned S_LSB = 0;
  localparam int unsigned K_LSB = 0;

  localparam int unsigned COEF_W = M_W + FRAC_W + 1;
  localparam int unsigned DEN_W  = P_W + FRAC_W + (2 ** S_W) - 1;

  typedef struct packed {
    logic [M_W-1:0]        m;
    logic [P_W-1:0]        p;
    logic [S_W-1:0]        s;
    logic signed [K_W-1:0] k;
  } pll_fields_t;
endpackage

// File: rtl/pllrate_unpack.sv
module pllrate_unpack
  import pllrate_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter bit          FRAC_EN = 1'b1
) (
  input  logic              mode_i,
  input  logic [WORD_W-1:0] div0_i,
  input  logic [WORD_W-1:0] div1_i,
  output pll_fields_t       fld_o
);
  always_comb begin
    fld_o.m = div0_i[M_LSB +: M_W];
    fld_o.p = div0_i[P_LSB +: P_W];
    fld_o.s = div0_i[S_LSB +: S_W];
  end

  generate
    if (FRAC_EN) begin : g_frac
      assign fld_o.k = mode_i ? $signed(div1_i[K_LSB +: K_W]) : '0;
    end else begin : g_int
      logic unused_w;
      assign unused_w = mode_i ^ (^div1_i);
      assign fld_o.k  = '0;
    end
  endgenerate
endmodule

// File: rtl/pllrate_numer.sv
module pllrate_numer
  import pllrate_pkg::*;
#(
  parameter int unsigned FIN_W = 32,
  parameter int unsigned NUM_W = 64
) (
  input  pll_fields_t       fld_i,
  input  logic [FIN_W-1:0]  fin_i,
  output logic [NUM_W-1:0]  mag_o,
  output logic              neg_o,
  output logic [DEN_W-1:0]  den_o
);
  logic signed [COEF_W-1:0] coef;
  logic        [COEF_W-1:0] coef_abs;

  always_comb begin
    coef     = $signed({1'b0, fld_i.m, {FRAC_W{1'b0}}})
             + $signed({{(COEF_W-K_W){fld_i.k[K_W-1]}}, fld_i.k});
    neg_o    = coef[COEF_W-1];
    coef_abs = neg_o ? COEF_W'(-coef) : COEF_W'(coef);
    mag_o    = NUM_W'(fin_i) * NUM_W'(coef_abs);
    den_o    = DEN_W'({fld_i.p, {FRAC_W{1'b0}}}) << fld_i.s;
  end
endmodule

// File: rtl/pllrate_divider.sv
module pllrate_divider #(
  parameter int unsigned NUM_W = 64,
  parameter int unsigned DEN_W = 29
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] dvd_i,
  input  logic [DEN_W-1:0] den_i,
  input  logic             neg_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [NUM_W-1:0] res_o
);
  localparam int unsigned CNT_W = $clog2(NUM_W + 1);

  logic             busy_q, done_q, err_q, neg_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NUM_W-1:0] dvd_q, quo_q, res_q;
  logic [DEN_W-1:0] rem_q, den_q;

  logic [DEN_W:0]   rem_sh, diff;
  logic             ge;
  logic [DEN_W-1:0] rem_nx;
  logic [NUM_W-1:0] quo_nx;

  always_comb begin
    rem_sh = {rem_q, dvd_q[NUM_W-1]};
    diff   = rem_sh - {1'b0, den_q};
    ge     = ~diff[DEN_W];
    rem_nx = ge ? diff[DEN_W-1:0] : rem_sh[DEN_W-1:0];
    quo_nx = {quo_q[NUM_W-2:0], ge};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      neg_q  <= 1'b0;
      cnt_q  <= '0;
      dvd_q  <= '0;
      quo_q  <= '0;
      res_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      res_q  <= '0;
      if (!busy_q) begin
        if (start_i) begin
          if (den_i == '0) begin
            done_q <= 1'b1;
            err_q  <= 1'b1;
          end else begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(NUM_W);
            dvd_q  <= dvd_i;
            den_q  <= den_i;
            neg_q  <= neg_i;
            rem_q  <= '0;
            quo_q  <= '0;
          end
        end
      end else begin
        dvd_q <= dvd_q << 1;
        rem_q <= rem_nx;
        quo_q <= quo_nx;
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          res_q  <= neg_q ? -quo_nx : quo_nx;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign err_o  = err_q;
  assign res_o  = res_q;

  assert_rem_below_den_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (rem_q < den_q));

  assert_busy_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != CNT_W'(1)) |=> (busy_q && $stable(den_q) && $stable(neg_q)));

  assert_err_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> (done_q && res_q == '0));
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
  import pllrate_pkg::*;
#(
  parameter int unsigned FIN_W   = 32,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned NUM_W   = 64,
  parameter bit          FRAC_EN = 1'b1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    mode_i,
  input  logic [WORD_W-1:0]       div0_i,
  input  logic [WORD_W-1:0]       div1_i,
  input  logic [FIN_W-1:0]        fin_i,
  output logic                    done_o,
  output logic                    err_o,
  output logic signed [NUM_W-1:0] freq_o
);
  pll_fields_t      fld;
  logic [NUM_W-1:0] mag;
  logic             neg;
  logic [DEN_W-1:0] den;
  logic             busy;
  logic [NUM_W-1:0] res;

  pllrate_unpack #(.WORD_W(WORD_W), .FRAC_EN(FRAC_EN)) u_unpack (
    .mode_i (mode_i),
    .div0_i (div0_i),
    .div1_i (div1_i),
    .fld_o  (fld)
  );

  pllrate_numer #(.FIN_W(FIN_W), .NUM_W(NUM_W)) u_numer (
    .fld_i (fld),
    .fin_i (fin_i),
    .mag_o (mag),
    .neg_o (neg),
    .den_o (den)
  );

  pllrate_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .dvd_i   (mag),
    .den_i   (den),
    .neg_i   (neg),
    .busy_o  (busy),
    .done_o  (done_o),
    .err_o   (err_o),
    .res_o   (res)
  );

  assign freq_o = $signed(res);

  assert_done_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |=> (!done_o || err_o));

  assert_idle_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (freq_o == '0 && !err_o));

  assert_done_not_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy);
endmodule

// File: tb/pll_rate_calc_tb.sv
`timescale 1ns/1ps
module pll_rate_calc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic [31:0] w0 = '0, w1 = '0, fin = '0;
  logic        done, err;
  logic signed [63:0] freq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pll_rate_calc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .div0_i(w0), .div1_i(w1), .fin_i(fin),
    .done_o(done), .err_o(err), .freq_o(freq)
  );

  function automatic longint expect_f(input logic md, input logic [31:0] a,
                                      input logic [31:0] b, input logic [31:0] f);
    longint m, p, s, k, num, den;
    m = longint'(a[21:12]);
    p = longint'(a[9:4]);
    s = longint'(a[2:0]);
    k = md ? longint'($signed(b[15:0])) : 0;
    num = longint'(f) * (m * 65536 + k);
    den = (p * 65536) << s;
    return (den == 0) ? 0 : num / den;
  endfunction

  function automatic logic [31:0] pack0(input int m, input int p, input int s);
    return (32'(m) << 12) | (32'(p) << 4) | 32'(s);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic launch(input logic md, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] f);
    @(negedge clk);
    mode = md; w0 = a; w1 = b; fin = f; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat, output longint f, output logic e);
    lat = 0;
    while (!done && lat < 200) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    f = freq; e = err;
  endtask

  task automatic run_case(input string req, input logic md, input logic [31:0] a,
                          input logic [31:0] b, input logic [31:0] f);
    int lat; longint r; logic e;
    launch(md, a, b, f);
    wait_done(lat, r, e);
    chk({req, " freq"}, r, expect_f(md, a, b, f));
    chk({req, " err"}, longint'(e), 0);
    chk({req, " latency"}, longint'(lat), 64);
    @(posedge clk); @(negedge clk);
    chk({req, " R5 single pulse"}, longint'(done), 0);
    chk({req, " R7 idle freq"}, freq, 0);
  endtask

  task automatic test_reset;
    chk("R7 reset done", longint'(done), 0);
    chk("R7 reset err", longint'(err), 0);
    chk("R7 reset freq", freq, 0);
  endtask

  task automatic test_integer;
    // R1: unused word0 bits set; R3: word1 garbage in integer mode
    run_case("R1 R3 integer", 1'b0, pack0(300, 3, 1) | 32'hFFC0_0C08, 32'hDEAD_7FFF, 32'd24_000_000);
    chk("R3 integer value", expect_f(1'b0, pack0(300, 3, 1), '0, 32'd24_000_000), 64'd1_200_000_000);
  endtask

  task automatic test_fractional;
    run_case("R2 R4 frac positive K", 1'b1, pack0(262, 2, 3), 32'hFFFF_0000 | 32'd9437, 32'd24_000_000);
    run_case("R2 R4 frac negative K", 1'b1, pack0(173, 2, 1), 32'h0000_C000, 32'd24_000_000);
    run_case("R4 range corner", 1'b1, pack0(1023, 63, 6), 32'h0000_7FFF, 32'hFFFF_FFFF);
  endtask

  task automatic test_negative;
    // -65537000 / 65536 truncates to -1000, not -1001
    run_case("R4 trunc toward zero", 1'b1, pack0(0, 1, 0), 32'h0000_FC18, 32'd65537);
    chk("R4 trunc value", expect_f(1'b1, pack0(0, 1, 0), 32'h0000_FC18, 32'd65537), -64'sd1000);
  endtask

  task automatic test_pzero;
    int lat; longint r; logic e;
    launch(1'b1, pack0(200, 0, 2), 32'h1234, 32'd24_000_000);
    wait_done(lat, r, e);
    chk("R6 zero P latency", longint'(lat), 0);
    chk("R6 zero P err", longint'(e), 1);
    chk("R6 zero P freq", r, 0);
    @(posedge clk); @(negedge clk);
    chk("R7 err cleared", longint'(err), 0);
  endtask

  task automatic test_ignore_start;
    int lat; longint a_exp;
    a_exp = expect_f(1'b0, pack0(250, 3, 1), '0, 32'd24_000_000);
    launch(1'b0, pack0(250, 3, 1), '0, 32'd24_000_000);
    lat = 0;
    while (!done && lat < 200) begin
      if (lat == 10) begin
        mode = 1'b1; w0 = pack0(100, 0, 0); w1 = 32'h7FFF; fin = 32'd1; start = 1'b1;
      end else if (lat == 11) begin
        start = 1'b0;
      end
      if (lat == 20) chk("R7 freq zero while busy", freq, 0);
      @(posedge clk); @(negedge clk); lat++;
    end
    chk("R8 ignored start freq", freq, a_exp);
    chk("R8 ignored start latency", longint'(lat), 64);
    @(posedge clk); @(negedge clk);
    chk("R8 no extra done", longint'(done), 0);
  endtask

  task automatic test_back_to_back;
    int lat; longint r; logic e; longint a_exp, b_exp;
    a_exp = expect_f(1'b1, pack0(325, 3, 2), '0, 32'd24_000_000);
    b_exp = expect_f(1'b1, pack0(198, 2, 2), '0, 32'd24_000_000);
    launch(1'b1, pack0(325, 3, 2), '0, 32'd24_000_000);
    wait_done(lat, r, e);
    chk("R9 first result", r, a_exp);
    // new request held high during the done cycle
    w0 = pack0(198, 2, 2); start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    chk("R9 done dropped", longint'(done), 0);
    wait_done(lat, r, e);
    chk("R9 second result", r, b_exp);
    chk("R9 second latency", longint'(lat), 64);
    // collision with a zero pre-divider request
    w0 = pack0(198, 0, 2); start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    chk("R9 R6 err pulse follows", longint'(done && err), 1);
    chk("R9 R6 err freq", freq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_integer();
    test_fractional();
    test_negative();
    test_pzero();
    test_ignore_start();
    test_back_to_back();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule